// File: doc/BRIEF.md
# Programmable Turn-On Delay Controller

This block sits between the on/off request for a switched load and the enable signal that drives that load. A three-bit delay code lives in a configuration register written through a simple address/data write port. When the serially commanded request rises, the block holds the load enable low for code × STEP_TICKS millisecond ticks, and then raises it. Releasing the request turns the enable off at once. If the request is released while a delay is still running, the pending turn-on is dropped.

Two other sources can take over the enable, and neither one is delayed. In direct mode the enable copies a direct input pin. In fail-safe mode it copies a fail-safe request, and fail-safe wins over both other sources. A clock prescaler produces the millisecond tick. The prescaler restarts on every detected rise, so each delay lasts an exact number of clock cycles. The serial delay sequence keeps running in the background while another source holds the output.

Top module: `turnon_delay_ctrl`

## Requirements
- R1: After reset, out_en is 0 and the stored delay code is 000, so the first serial rise turns the output on with no delay.
- R2: A write with cfg_we high and cfg_addr equal to 4'b0101 stores cfg_data[2:0] as the delay code. Writes to any other address, and cfg_data bits 7 to 3, have no effect.
- R3: With code 000, a rise of ser_req sampled at clock edge E makes out_en 1 right after E.
- R4: With code c > 0, after a rise of ser_req sampled at edge E, out_en stays 0 through edge E + c·STEP_TICKS·TICK_CYCLES − 1 and becomes 1 at edge E + c·STEP_TICKS·TICK_CYCLES.
- R5: If ser_req falls before the delay expires, including in the same cycle as the final tick, out_en stays 0 and the pending turn-on is dropped. The next rise starts a full new delay.
- R6: In serial mode, ser_req sampled low at an edge makes out_en 0 right after that edge.
- R7: The delay code is captured at the edge that detects the rise. A register write at that same edge, or at any later edge during the delay, does not change the running delay.
- R8: With dir_sel high and fs_mode low, out_en copies dir_in one edge later, whatever the delay code.
- R9: With fs_mode high, out_en copies fs_req one edge later. This overrides the direct and serial sources, and the delay has no effect.
- R10: The serial sequence keeps running while direct or fail-safe mode holds the output. When serial mode returns, out_en takes the serial state at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_data | input | DATA_W | Configuration write data |
| ser_req | input | 1 | Serially commanded on request |
| dir_sel | input | 1 | Selects the direct input as the output source |
| dir_in | input | 1 | Direct on request |
| fs_mode | input | 1 | Fail-safe override active |
| fs_req | input | 1 | Output value demanded in fail-safe mode |
| out_en | output | 1 | Registered load enable |

## Verification
Two events can land in the same clock cycle, and the bench forces both.

- **Write during rise detection:** a write to the delay register is driven in the same cycle as a serial rise. The bench expects the enable to appear after the delay given by the old code, not the new one.
- **Release on the final tick:** the request is dropped in the exact cycle whose edge carries the last tick of a seven-step delay. The bench expects the enable to stay low, because the release wins.

A scoreboard queue holds every expected output value against the cycle in which it must appear. The edges just before and just at each expiry are both checked.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    // Output source selection, highest priority first in tdc_pick_mode.
    typedef enum logic [1:0] {
        TDC_SERIAL = 2'd0,
        TDC_DIRECT = 2'd1,
        TDC_SAFE   = 2'd2
    } tdc_mode_e;

    function automatic tdc_mode_e tdc_pick_mode(input logic safe, input logic direct);
        if (safe) begin
            return TDC_SAFE;
        end else if (direct) begin
            return TDC_DIRECT;
        end
        return TDC_SERIAL;
    endfunction

endpackage

// File: rtl/tdc_tick_gen.sv
module tdc_tick_gen #(
    parameter int TICK_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (restart) begin
            st_d.pre = '0;
        end else if (st_q.pre == PRE_LAST) begin
            st_d.pre = '0;
            tick     = 1'b1;
        end else begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pre <= PRE_LAST);

    // R4
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.pre == '0));

endmodule

// File: rtl/tdc_code_map.sv
module tdc_code_map #(
    parameter int CODE_W     = 3,
    parameter int STEP_TICKS = 75,
    parameter int TGT_W      = 10
) (
    input  logic [CODE_W-1:0] code,
    output logic [TGT_W-1:0]  target
);
    localparam int NUM_CODES = 1 << CODE_W;

    logic [TGT_W-1:0] lut [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_step
        assign lut[g] = TGT_W'(g * STEP_TICKS);
    end

    assign target = lut[code];

endmodule

// File: rtl/tdc_sequencer.sv
module tdc_sequencer #(
    parameter int TGT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [TGT_W-1:0] target_in,
    input  logic             tick,
    output logic             restart,
    output logic             on_nxt
);
    typedef struct packed {
        logic             prev;
        logic             pending;
        logic             on;
        logic [TGT_W-1:0] tgt;
        logic [TGT_W-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    rise;

    assign rise    = req & ~st_q.prev;
    assign restart = rise;
    assign on_nxt  = st_d.on;

    always_comb begin
        st_d      = st_q;
        st_d.prev = req;
        if (!req) begin
            st_d.pending = 1'b0;
            st_d.on      = 1'b0;
            st_d.cnt     = '0;
        end else if (rise) begin
            st_d.cnt = '0;
            st_d.tgt = target_in;
            if (target_in == '0) begin
                st_d.on      = 1'b1;
                st_d.pending = 1'b0;
            end else begin
                st_d.on      = 1'b0;
                st_d.pending = 1'b1;
            end
        end else if (st_q.pending && tick) begin
            if (st_q.cnt + TGT_W'(1) == st_q.tgt) begin
                st_d.pending = 1'b0;
                st_d.on      = 1'b1;
                st_d.cnt     = '0;
            end else begin
                st_d.cnt = st_q.cnt + TGT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && target_in == '0) |=> st_q.on);

    // R4
    held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && target_in != '0) |=> (st_q.pending && !st_q.on));

    // R5
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!st_q.on && !st_q.pending));

    // R7
    frozen_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending && req && !rise) |=> $stable(st_q.tgt));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pending |-> (st_q.cnt < st_q.tgt));

endmodule

// File: rtl/turnon_delay_ctrl.sv
module turnon_delay_ctrl
    import tdc_pkg::*;
#(
    parameter int               TICK_CYCLES = 200000,
    parameter int               STEP_TICKS  = 75,
    parameter int               CODE_W      = 3,
    parameter int               ADDR_W      = 4,
    parameter int               DATA_W      = 8,
    parameter logic [ADDR_W-1:0] DELAY_ADDR = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              ser_req,
    input  logic              dir_sel,
    input  logic              dir_in,
    input  logic              fs_mode,
    input  logic              fs_req,
    output logic              out_en
);
    localparam int MAX_TICKS = ((1 << CODE_W) - 1) * STEP_TICKS;
    localparam int TGT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS + 1) : 1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              out;
    } top_st_t;

    top_st_t          st_d, st_q;
    tdc_mode_e        mode;
    logic [TGT_W-1:0] target;
    logic             tick;
    logic             restart;
    logic             ser_on_nxt;
    logic             unused_cfg_hi;

    assign unused_cfg_hi = ^cfg_data[DATA_W-1:CODE_W];

    tdc_code_map #(
        .CODE_W     (CODE_W),
        .STEP_TICKS (STEP_TICKS),
        .TGT_W      (TGT_W)
    ) u_map (
        .code   (st_q.code),
        .target (target)
    );

    tdc_tick_gen #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    tdc_sequencer #(
        .TGT_W (TGT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ser_req),
        .target_in (target),
        .tick      (tick),
        .restart   (restart),
        .on_nxt    (ser_on_nxt)
    );

    assign mode = tdc_pick_mode(fs_mode, dir_sel);

    always_comb begin
        st_d = st_q;
        if (cfg_we && cfg_addr == DELAY_ADDR) begin
            st_d.code = cfg_data[CODE_W-1:0];
        end
        unique case (mode)
            TDC_SAFE:   st_d.out = fs_req;
            TDC_DIRECT: st_d.out = dir_in;
            default:    st_d.out = ser_on_nxt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_en = st_q.out;

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_addr == DELAY_ADDR) |=> $stable(st_q.code));

    // R6
    serial_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_mode && !dir_sel && !ser_req) |=> !out_en);

    // R8
    direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_mode && dir_sel) |=> (out_en == $past(dir_in)));

    // R9
    failsafe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_mode |=> (out_en == $past(fs_req)));

endmodule

// File: tb/turnon_delay_ctrl_test.sv
module turnon_delay_ctrl_test;

    localparam int TICKS = 4;
    localparam int STEP  = 3;
    localparam int UNIT  = TICKS * STEP;

    typedef struct {
        int    cyc;
        logic  val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_data = '0;
    logic       ser_req = 1'b0;
    logic       dir_sel = 1'b0;
    logic       dir_in = 1'b0;
    logic       fs_mode = 1'b0;
    logic       fs_req = 1'b0;
    logic       out_en;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    turnon_delay_ctrl #(
        .TICK_CYCLES (TICKS),
        .STEP_TICKS  (STEP)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .ser_req  (ser_req),
        .dir_sel  (dir_sel),
        .dir_in   (dir_in),
        .fs_mode  (fs_mode),
        .fs_req   (fs_req),
        .out_en   (out_en)
    );

    // Driver side: queue an expected value for the cycle 'off' edges ahead.
    task automatic expect_at(input int off, input logic v, input string tag);
        exp_t e;
        int   pos;
        e.cyc = cyc + off;
        e.val = v;
        e.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].cyc > e.cyc) begin
                pos = i;
                break;
            end
        end
        sb.insert(pos, e);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = a;
        cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor side: pop and compare every item due in this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.cyc != cyc || out_en !== e.val) begin
                errors++;
                $display("FAIL %s cycle %0d: out_en=%0b expected %0b (due %0d)",
                         e.tag, cyc, out_en, e.val, e.cyc);
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements): run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_cyc(1);
        expect_at(1, 1'b0, "R1");
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 / R3: default code zero, immediate turn-on
        @(negedge clk);
        ser_req = 1'b1;
        expect_at(1, 1'b1, "R3");
        expect_at(1, 1'b1, "R1");
        wait_cyc(3);
        ser_req = 1'b0;
        expect_at(1, 1'b0, "R6");
        wait_cyc(2);

        // R4: code 2
        cfg_write(4'b0101, 8'h02);
        ser_req = 1'b1;
        expect_at(2 * UNIT, 1'b0, "R4");
        expect_at(2 * UNIT + 1, 1'b1, "R4");
        wait_cyc(2 * UNIT + 5);
        ser_req = 1'b0;
        expect_at(1, 1'b0, "R6");
        wait_cyc(2);

        // R4: code 7
        cfg_write(4'b0101, 8'h07);
        ser_req = 1'b1;
        expect_at(7 * UNIT, 1'b0, "R4");
        expect_at(7 * UNIT + 1, 1'b1, "R4");
        wait_cyc(7 * UNIT + 5);
        ser_req = 1'b0;
        wait_cyc(2);

        // R5: cancel mid-delay, then full restart
        ser_req = 1'b1;
        wait_cyc(40);
        ser_req = 1'b0;
        expect_at(1, 1'b0, "R5");
        expect_at(60, 1'b0, "R5");
        wait_cyc(62);
        ser_req = 1'b1;
        expect_at(7 * UNIT, 1'b0, "R5");
        expect_at(7 * UNIT + 1, 1'b1, "R5");
        wait_cyc(7 * UNIT + 5);
        ser_req = 1'b0;
        wait_cyc(2);

        // R5: release in the cycle of the final tick
        ser_req = 1'b1;
        wait_cyc(7 * UNIT);
        ser_req = 1'b0;
        expect_at(1, 1'b0, "R5");
        expect_at(5, 1'b0, "R5");
        wait_cyc(10);

        // R7: write in the detection cycle keeps the old code (3)
        cfg_write(4'b0101, 8'h03);
        cfg_we   = 1'b1;
        cfg_addr = 4'b0101;
        cfg_data = 8'h01;
        ser_req  = 1'b1;
        expect_at(3 * UNIT, 1'b0, "R7");
        expect_at(3 * UNIT + 1, 1'b1, "R7");
        @(negedge clk);
        cfg_we = 1'b0;
        wait_cyc(3 * UNIT + 4);
        ser_req = 1'b0;
        wait_cyc(2);

        // R7: rewrite during a running delay (code now 1)
        ser_req = 1'b1;
        expect_at(UNIT, 1'b0, "R7");
        expect_at(UNIT + 1, 1'b1, "R7");
        wait_cyc(2);
        cfg_we   = 1'b1;
        cfg_data = 8'h06;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_cyc(UNIT + 4);
        ser_req = 1'b0;
        wait_cyc(2);

        // R2: upper data bits and other addresses ignored
        cfg_write(4'b0101, 8'hF9);
        cfg_write(4'b0100, 8'h07);
        ser_req = 1'b1;
        expect_at(UNIT, 1'b0, "R2");
        expect_at(UNIT + 1, 1'b1, "R2");
        wait_cyc(UNIT + 5);
        ser_req = 1'b0;
        wait_cyc(2);

        // R8: direct input, no delay
        dir_sel = 1'b1;
        dir_in  = 1'b1;
        expect_at(1, 1'b1, "R8");
        wait_cyc(3);
        dir_in = 1'b0;
        expect_at(1, 1'b0, "R8");
        wait_cyc(3);

        // R9: fail-safe overrides direct
        fs_mode = 1'b1;
        fs_req  = 1'b1;
        expect_at(1, 1'b1, "R9");
        wait_cyc(3);
        fs_req = 1'b0;
        expect_at(1, 1'b0, "R9");
        wait_cyc(2);
        dir_sel = 1'b0;
        wait_cyc(1);

        // R9 / R10: serial delay expires under fail-safe, shows on exit
        ser_req = 1'b1;
        expect_at(UNIT + 1, 1'b0, "R9");
        wait_cyc(UNIT + 8);
        fs_mode = 1'b0;
        expect_at(1, 1'b1, "R10");
        wait_cyc(3);
        ser_req = 1'b0;
        expect_at(1, 1'b0, "R6");
        wait_cyc(3);

        // R10: fail-safe released mid-delay, serial delay still on time
        fs_mode = 1'b1;
        ser_req = 1'b1;
        expect_at(UNIT, 1'b0, "R10");
        expect_at(UNIT + 1, 1'b1, "R10");
        wait_cyc(3);
        fs_mode = 1'b0;
        wait_cyc(UNIT + 2);
        ser_req = 1'b0;
        wait_cyc(5);

        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R4 scoreboard: %0d items left, expected 0", sb.size());
        end
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule